// File: doc/BRIEF.md
# Maintenance Request to Memory-Mapped Bridge

This block sits between the logical layer of a serial interconnect endpoint and a simple memory-mapped master bus. It takes MAINTENANCE read and write requests that have already been parsed into header fields plus one 32-bit payload word. It turns each valid request into exactly one single-word transfer on the master bus. When that transfer finishes, it returns a response packet, as parsed fields, towards the transport side.

The bus address comes from the request's configuration offset and its word pointer. The word pointer is inverted before use, so it selects the other 32-bit half of a double-word. Only the single-word size code is accepted. A request with any other size code gets an error response and causes no bus activity. Transaction types other than read and write, port-write among them, never reach the bus. They leave through a separate side output.

Only one request is in flight at a time. The request input stays back-pressured until the matching response or side item has been taken downstream.

Top module: `maint_bus_bridge`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the edge on which the matching response (`rsp_valid && rsp_ready`) or side item (`side_valid && side_ready`) is accepted, and is high again in the following cycle.
- R2: A read request (type 4'd0, size 4'b1000) produces exactly one read transfer on the bus and no write transfer.
- R3: During any bus transfer the address equals config offset × 8, plus 4 when the word pointer is 0. Bits 31:24 and 1:0 are zero.
- R4: A write request (type 4'd1, size 4'b1000) produces exactly one write transfer, and `bus_writedata` carries the payload word.
- R5: `bus_read` and `bus_write` are never high together. While `bus_waitrequest` is high, the active command, its address and its write data stay unchanged.
- R6: A read response is type 4'd2 with status 4'd0. It carries the data seen with `bus_readdatavalid` and echoes the request's TID. `readdatavalid` may arrive in the cycle the command is accepted or any later cycle. A `readdatavalid` with no read pending produces no response.
- R7: A write response is type 4'd3 with status 4'd0 and zero data, and echoes the TID. It appears the cycle after the write is accepted (`waitrequest` low).
- R8: A read or write request whose size field is not 4'b1000 makes no bus transfer. It is answered in the cycle after acceptance with status 4'd7 and zero data. The response type is 4'd2 for a read and 4'd3 for a write, and the TID is echoed.
- R9: A request with any type from 4'd2 to 4'd15 (port-write included) makes no bus transfer and no response. It appears on the side output in the next cycle with its type, size, TID, offset, word pointer and payload.
- R10: A pending response or side item keeps its valid and all its fields stable until it is accepted.
- R11: After reset, `req_ready` is high and `rsp_valid`, `side_valid`, `bus_read` and `bus_write` are low. A reset during a transfer drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_ttype | input | 4 | Transaction type (0 read, 1 write, other: side) |
| req_size | input | 4 | Size code, 4'b1000 is one word |
| req_tid | input | TID_W | Transaction ID |
| req_offset | input | 21 | Configuration offset (double-word index) |
| req_wdptr | input | 1 | Word pointer |
| req_data | input | 32 | Payload word for writes |
| bus_address | output | 32 | Master byte address |
| bus_read | output | 1 | Read command |
| bus_write | output | 1 | Write command |
| bus_writedata | output | 32 | Write data |
| bus_readdata | input | 32 | Read data |
| bus_waitrequest | input | 1 | Slave stalls the command |
| bus_readdatavalid | input | 1 | Read data is valid |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_ttype | output | 4 | Response type (2 read, 3 write) |
| rsp_status | output | 4 | 0 done, 7 error |
| rsp_tid | output | TID_W | Echoed transaction ID |
| rsp_data | output | 32 | Read data or zero |
| side_valid | output | 1 | Forwarded non-read/write request present |
| side_ready | input | 1 | Downstream takes the side item |
| side_ttype | output | 4 | Forwarded type |
| side_size | output | 4 | Forwarded size |
| side_tid | output | TID_W | Forwarded ID |
| side_offset | output | 21 | Forwarded offset |
| side_wdptr | output | 1 | Forwarded word pointer |
| side_data | output | 32 | Forwarded payload |

## Verification
Reads and writes are driven with 0 to 3 stall cycles. Reads also get read-data latencies of 0 to 3 cycles. This separates a bridge that samples data in the acceptance cycle from one that waits for `readdatavalid`, and shows whether the command and address are held while the bus stalls. Both word-pointer values and the lowest and highest offsets are used to expose an address bit that is uninverted or misplaced. Requests with bad size codes and with non-read/write types are mixed in among good ones. A transfer counter watched at the bus then tells an error or side item apart from a silently issued access. A stray `readdatavalid` and a reset during a stalled read round off the corner cases.

// File: rtl/maint_bridge_pkg.sv
package maint_bridge_pkg;

  localparam int OFFSET_W = 21;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8 + OFFSET_W + 3;

  localparam logic [3:0] TT_READ   = 4'd0;
  localparam logic [3:0] TT_WRITE  = 4'd1;
  localparam logic [3:0] TT_RD_RSP = 4'd2;
  localparam logic [3:0] TT_WR_RSP = 4'd3;
  localparam logic [3:0] ST_DONE   = 4'd0;
  localparam logic [3:0] ST_ERROR  = 4'd7;
  localparam logic [3:0] SZ_WORD   = 4'b1000;

  typedef enum logic [2:0] {
    K_READ, K_WRITE, K_ERR_RD, K_ERR_WR, K_SIDE
  } req_kind_e;

  // Byte address: upper byte zero, offset picks the double-word,
  // inverted word pointer picks the half, low two bits zero.
  function automatic logic [ADDR_W-1:0] make_bus_addr(
    input logic [OFFSET_W-1:0] offset, input logic wdptr);
    return {8'h00, offset, ~wdptr, 2'b00};
  endfunction

  function automatic req_kind_e classify(input logic [3:0] ttype,
                                         input logic [3:0] size);
    req_kind_e k;
    case (ttype)
      TT_READ:  k = (size == SZ_WORD) ? K_READ  : K_ERR_RD;
      TT_WRITE: k = (size == SZ_WORD) ? K_WRITE : K_ERR_WR;
      default:  k = K_SIDE;
    endcase
    return k;
  endfunction

  function automatic logic [3:0] rsp_type_for(input req_kind_e k);
    return (k == K_READ || k == K_ERR_RD) ? TT_RD_RSP : TT_WR_RSP;
  endfunction

  function automatic logic is_error_kind(input req_kind_e k);
    return (k == K_ERR_RD) || (k == K_ERR_WR);
  endfunction

endpackage

// File: rtl/maint_req_decode.sv
module maint_req_decode
  import maint_bridge_pkg::*;
(
  input  logic [3:0] ttype,
  input  logic [3:0] size,
  output req_kind_e  kind,
  output logic       to_bus,
  output logic       to_error,
  output logic       to_side
);

  always_comb begin
    kind     = classify(ttype, size);
    to_bus   = (kind == K_READ) || (kind == K_WRITE);
    to_error = is_error_kind(kind);
    to_side  = (kind == K_SIDE);
  end

  // R8/R9: the three routes are mutually exclusive and cover all codes
  always_comb begin
    a_route_onehot_r9: assert ($countones({to_bus, to_error, to_side}) == 1)
      else $error("request routed to %0d paths", $countones({to_bus, to_error, to_side}));
  end

endmodule

// File: rtl/maint_bus_engine.sv
module maint_bus_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic [ADDR_W-1:0] bus_address,
  output logic              bus_read,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_writedata,
  input  logic [DATA_W-1:0] bus_readdata,
  input  logic              bus_waitrequest,
  input  logic              bus_readdatavalid,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              busy
);

  typedef enum logic [1:0] {E_IDLE, E_RD_CMD, E_RD_WAIT, E_WR_CMD} eng_st_e;
  eng_st_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // named internal events
  logic cmd_taken;
  logic rd_data_in;

  always_comb begin
    cmd_taken  = (st_q == E_RD_CMD || st_q == E_WR_CMD) && !bus_waitrequest;
    rd_data_in = (st_q == E_RD_CMD || st_q == E_RD_WAIT) && bus_readdatavalid;
    st_d = st_q;
    done = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (start_rd)      st_d = E_RD_CMD;
        else if (start_wr) st_d = E_WR_CMD;
      end
      E_RD_CMD: begin
        if (cmd_taken) begin
          if (rd_data_in) begin
            done = 1'b1;
            st_d = E_IDLE;
          end else begin
            st_d = E_RD_WAIT;
          end
        end
      end
      E_RD_WAIT: begin
        if (rd_data_in) begin
          done = 1'b1;
          st_d = E_IDLE;
        end
      end
      E_WR_CMD: begin
        if (cmd_taken) begin
          done = 1'b1;
          st_d = E_IDLE;
        end
      end
      default: st_d = E_IDLE;
    endcase
    done_data = (st_q == E_WR_CMD) ? '0 : bus_readdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == E_IDLE && (start_rd || start_wr)) begin
        addr_q  <= start_addr;
        wdata_q <= start_wdata;
      end
    end
  end

  assign bus_address   = addr_q;
  assign bus_read      = (st_q == E_RD_CMD);
  assign bus_write     = (st_q == E_WR_CMD);
  assign bus_writedata = wdata_q;
  assign busy          = (st_q != E_IDLE);

  // R5: never both commands at once
  p_one_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

  // R5: stalled command holds command, address and data
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read || bus_write) && bus_waitrequest |=>
      (bus_read == $past(bus_read)) && (bus_write == $past(bus_write)) &&
      $stable(bus_address) && $stable(bus_writedata));

  // R2/R4: a new start only while idle
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |-> !busy);

endmodule

// File: rtl/maint_rsp_slot.sv
module maint_rsp_slot #(
  parameter int TID_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [3:0]        ld_ttype,
  input  logic [3:0]        ld_status,
  input  logic [TID_W-1:0]  ld_tid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [3:0]        rsp_ttype,
  output logic [3:0]        rsp_status,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [DATA_W-1:0] rsp_data
);

  logic fire;
  assign fire = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_ttype  <= '0;
      rsp_status <= '0;
      rsp_tid    <= '0;
      rsp_data   <= '0;
    end else if (load) begin
      rsp_valid  <= 1'b1;
      rsp_ttype  <= ld_ttype;
      rsp_status <= ld_status;
      rsp_tid    <= ld_tid;
      rsp_data   <= ld_data;
    end else if (fire) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1: a new response never lands on an unconsumed one
  p_no_overwrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !rsp_valid);

  // R10: pending response is held unchanged
  p_rsp_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ttype) &&
      $stable(rsp_status) && $stable(rsp_tid) && $stable(rsp_data));

endmodule

// File: rtl/maint_bus_bridge.sv
module maint_bus_bridge
  import maint_bridge_pkg::*;
#(
  parameter int TID_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_ttype,
  input  logic [3:0]          req_size,
  input  logic [TID_W-1:0]    req_tid,
  input  logic [OFFSET_W-1:0] req_offset,
  input  logic                req_wdptr,
  input  logic [DATA_W-1:0]   req_data,
  output logic [ADDR_W-1:0]   bus_address,
  output logic                bus_read,
  output logic                bus_write,
  output logic [DATA_W-1:0]   bus_writedata,
  input  logic [DATA_W-1:0]   bus_readdata,
  input  logic                bus_waitrequest,
  input  logic                bus_readdatavalid,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [3:0]          rsp_ttype,
  output logic [3:0]          rsp_status,
  output logic [TID_W-1:0]    rsp_tid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                side_valid,
  input  logic                side_ready,
  output logic [3:0]          side_ttype,
  output logic [3:0]          side_size,
  output logic [TID_W-1:0]    side_tid,
  output logic [OFFSET_W-1:0] side_offset,
  output logic                side_wdptr,
  output logic [DATA_W-1:0]   side_data
);

  // named internal events
  logic      accept;
  req_kind_e kind_now;
  logic      now_bus, now_err, now_side;
  logic      rsp_fire, side_fire;
  logic      eng_done, eng_busy;
  logic [DATA_W-1:0] eng_data;

  logic      busy_q;
  req_kind_e cap_kind;
  logic [TID_W-1:0] cap_tid;
  logic      cap_wdptr;

  logic              rsp_load;
  logic [3:0]        ld_ttype, ld_status;
  logic [TID_W-1:0]  ld_tid;
  logic [DATA_W-1:0] ld_data;

  maint_req_decode u_decode (
    .ttype    (req_ttype),
    .size     (req_size),
    .kind     (kind_now),
    .to_bus   (now_bus),
    .to_error (now_err),
    .to_side  (now_side)
  );

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign side_fire = side_valid && side_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cap_kind  <= K_SIDE;
      cap_tid   <= '0;
      cap_wdptr <= 1'b0;
    end else begin
      if (rsp_fire || side_fire) busy_q <= 1'b0;
      else if (accept)           busy_q <= 1'b1;
      if (accept) begin
        cap_kind  <= kind_now;
        cap_tid   <= req_tid;
        cap_wdptr <= req_wdptr;
      end
    end
  end

  maint_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk               (clk),
    .rst_n             (rst_n),
    .start_rd          (accept && now_bus && kind_now == K_READ),
    .start_wr          (accept && now_bus && kind_now == K_WRITE),
    .start_addr        (make_bus_addr(req_offset, req_wdptr)),
    .start_wdata       (req_data),
    .bus_address       (bus_address),
    .bus_read          (bus_read),
    .bus_write         (bus_write),
    .bus_writedata     (bus_writedata),
    .bus_readdata      (bus_readdata),
    .bus_waitrequest   (bus_waitrequest),
    .bus_readdatavalid (bus_readdatavalid),
    .done              (eng_done),
    .done_data         (eng_data),
    .busy              (eng_busy)
  );

  always_comb begin
    rsp_load  = (accept && now_err) || eng_done;
    ld_ttype  = eng_done ? rsp_type_for(cap_kind) : rsp_type_for(kind_now);
    ld_status = eng_done ? ST_DONE : ST_ERROR;
    ld_tid    = eng_done ? cap_tid : req_tid;
    ld_data   = eng_done ? eng_data : '0;
  end

  maint_rsp_slot #(.TID_W(TID_W), .DATA_W(DATA_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (rsp_load),
    .ld_ttype   (ld_ttype),
    .ld_status  (ld_status),
    .ld_tid     (ld_tid),
    .ld_data    (ld_data),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_ttype  (rsp_ttype),
    .rsp_status (rsp_status),
    .rsp_tid    (rsp_tid),
    .rsp_data   (rsp_data)
  );

  // side output for every type that is neither read nor write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side_valid  <= 1'b0;
      side_ttype  <= '0;
      side_size   <= '0;
      side_tid    <= '0;
      side_offset <= '0;
      side_wdptr  <= 1'b0;
      side_data   <= '0;
    end else if (accept && now_side) begin
      side_valid  <= 1'b1;
      side_ttype  <= req_ttype;
      side_size   <= req_size;
      side_tid    <= req_tid;
      side_offset <= req_offset;
      side_wdptr  <= req_wdptr;
      side_data   <= req_data;
    end else if (side_fire) begin
      side_valid <= 1'b0;
    end
  end

  // R1: nothing new is taken while an item is waiting downstream
  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || side_valid || eng_busy) |-> !req_ready);

  // R3: address shape during a transfer, half selected by inverted pointer
  p_addr_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read || bus_write) |-> (bus_address[31:24] == 8'h00) &&
      (bus_address[1:0] == 2'b00) && (bus_address[2] == !cap_wdptr));

  // R8: an error request never reaches the bus
  p_no_bus_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && is_error_kind(cap_kind) |-> !bus_read && !bus_write);

  // R9: a side item never coexists with a bus command or a response
  p_side_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    side_valid |-> !bus_read && !bus_write && !rsp_valid);

  // R10: pending side item is held unchanged
  p_side_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    side_valid && !side_ready |=> side_valid && $stable(side_ttype) &&
      $stable(side_tid) && $stable(side_offset) && $stable(side_data) &&
      $stable(side_size) && $stable(side_wdptr));

endmodule

// File: tb/maint_bus_bridge_test.sv
`timescale 1ns/100ps
module maint_bus_bridge_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [3:0]  req_ttype = 0, req_size = 0;
  logic [7:0]  req_tid = 0;
  logic [20:0] req_offset = 0;
  logic        req_wdptr = 0;
  logic [31:0] req_data = 0;
  logic [31:0] bus_address, bus_writedata;
  logic        bus_read, bus_write;
  logic [31:0] bus_readdata = 0;
  logic        bus_waitrequest = 0, bus_readdatavalid = 0;
  logic        rsp_valid, rsp_ready = 0;
  logic [3:0]  rsp_ttype, rsp_status;
  logic [7:0]  rsp_tid;
  logic [31:0] rsp_data;
  logic        side_valid, side_ready = 0;
  logic [3:0]  side_ttype, side_size;
  logic [7:0]  side_tid;
  logic [20:0] side_offset;
  logic        side_wdptr;
  logic [31:0] side_data;

  maint_bus_bridge #(.TID_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ttype(req_ttype),
    .req_size(req_size), .req_tid(req_tid), .req_offset(req_offset),
    .req_wdptr(req_wdptr), .req_data(req_data),
    .bus_address(bus_address), .bus_read(bus_read), .bus_write(bus_write),
    .bus_writedata(bus_writedata), .bus_readdata(bus_readdata),
    .bus_waitrequest(bus_waitrequest), .bus_readdatavalid(bus_readdatavalid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ttype(rsp_ttype),
    .rsp_status(rsp_status), .rsp_tid(rsp_tid), .rsp_data(rsp_data),
    .side_valid(side_valid), .side_ready(side_ready), .side_ttype(side_ttype),
    .side_size(side_size), .side_tid(side_tid), .side_offset(side_offset),
    .side_wdptr(side_wdptr), .side_data(side_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int xfer_cnt = 0;

  // observer: count bus transfers accepted by the slave
  always @(posedge clk)
    if (rst_n && (bus_read || bus_write) && !bus_waitrequest) xfer_cnt <= xfer_cnt + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  tt;
    logic [3:0]  sz;
    logic [7:0]  tid;
    logic [20:0] off;
    logic        wp;
    logic [31:0] dat;
    logic [3:0]  stall;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 4'b1000, 8'h11, 21'h000010, 1'b0, 32'h1234_5678, 4'd0, 4'd0},
    '{4'd0, 4'b1000, 8'h22, 21'h0ABCDE, 1'b1, 32'hCAFE_F00D, 4'd2, 4'd3},
    '{4'd1, 4'b1000, 8'h33, 21'h1FFFFF, 1'b0, 32'hDEAD_BEEF, 4'd0, 4'd0},
    '{4'd1, 4'b1000, 8'h44, 21'h000000, 1'b1, 32'h0BAD_C0DE, 4'd3, 4'd0},
    '{4'd0, 4'b0100, 8'h55, 21'h000123, 1'b0, 32'h1111_1111, 4'd0, 4'd0},
    '{4'd1, 4'b1111, 8'h66, 21'h000456, 1'b1, 32'h2222_2222, 4'd0, 4'd0},
    '{4'd4, 4'b1000, 8'h77, 21'h000789, 1'b1, 32'h3333_3333, 4'd0, 4'd0},
    '{4'd15,4'b0000, 8'h88, 21'h1F0F0F, 1'b0, 32'h4444_4444, 4'd0, 4'd0},
    '{4'd0, 4'b1000, 8'h99, 21'h000000, 1'b0, 32'hFFFF_0000, 4'd1, 4'd1},
    '{4'd1, 4'b0000, 8'hAA, 21'h000055, 1'b0, 32'h5555_5555, 4'd0, 4'd0},
    '{4'd0, 4'b1000, 8'hBB, 21'h1FFFFF, 1'b1, 32'h8000_0001, 4'd0, 4'd2}
  };

  // response handshake: check fields, stall one cycle, then accept
  task automatic take_rsp(input string tag, input logic [3:0] ett, input logic [3:0] est,
                          input logic [7:0] etid, input logic [31:0] edat);
    check({tag, " rsp_valid"}, rsp_valid, 1);
    check({tag, " rsp_ttype"}, rsp_ttype, ett);
    check({tag, " rsp_status"}, rsp_status, est);
    check({tag, " rsp_tid"}, rsp_tid, etid);
    check({tag, " rsp_data"}, rsp_data, edat);
    rsp_ready = 0;
    @(negedge clk);
    check("R10 rsp held", {rsp_valid, rsp_ttype, rsp_status, rsp_tid, rsp_data},
          {1'b1, ett, est, etid, edat});
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 0;
    check("R1 rsp gone", rsp_valid, 0);
    check("R1 ready again", req_ready, 1);
  endtask

  task automatic run_vec(input vec_t v);
    logic is_side, is_err, is_rd;
    logic [31:0] exp_addr;
    logic [3:0] ett;
    int cnt0;
    is_side  = v.tt > 4'd1;
    is_err   = !is_side && (v.sz != 4'b1000);
    is_rd    = (v.tt == 4'd0);
    ett      = is_rd ? 4'd2 : 4'd3;
    exp_addr = (32'(v.off) << 3) + (v.wp ? 32'd0 : 32'd4);
    @(negedge clk);
    req_ttype = v.tt; req_size = v.sz; req_tid = v.tid;
    req_offset = v.off; req_wdptr = v.wp; req_data = v.dat;
    req_valid = 1;
    check("R1 ready when idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cnt0 = xfer_cnt;
    check("R1 busy after accept", req_ready, 0);
    if (is_side) begin
      check("R9 side fields", {side_valid, side_ttype, side_size, side_tid, side_offset, side_wdptr, side_data},
            {1'b1, v.tt, v.sz, v.tid, v.off, v.wp, v.dat});
      check("R9 no bus", {bus_read, bus_write, rsp_valid}, 3'b000);
      @(negedge clk);
      check("R10 side held", {side_valid, side_tid, side_data}, {1'b1, v.tid, v.dat});
      side_ready = 1;
      @(posedge clk);
      @(negedge clk);
      side_ready = 0;
      check("R9 side gone, no response", {side_valid, rsp_valid}, 2'b00);
      check("R9 no transfer", xfer_cnt, cnt0);
      check("R1 ready after side", req_ready, 1);
    end else if (is_err) begin
      check("R8 no bus", {bus_read, bus_write}, 2'b00);
      take_rsp("R8", ett, 4'd7, v.tid, 32'd0);
      check("R8 no transfer", xfer_cnt, cnt0);
    end else begin
      bus_waitrequest = (v.stall != 0);
      for (int i = 0; i < int'(v.stall); i++) begin
        check(is_rd ? "R5 read held" : "R5 write held", {bus_read, bus_write}, is_rd ? 2'b10 : 2'b01);
        check("R3 address stalled", bus_address, exp_addr);
        @(negedge clk);
      end
      bus_waitrequest = 0;
      check(is_rd ? "R2 read cmd" : "R4 write cmd", {bus_read, bus_write}, is_rd ? 2'b10 : 2'b01);
      check("R3 address", bus_address, exp_addr);
      if (!is_rd) check("R4 writedata", bus_writedata, v.dat);
      if (is_rd && v.lat == 0) begin
        bus_readdatavalid = 1; bus_readdata = v.dat;
      end
      @(posedge clk);
      @(negedge clk);
      bus_readdatavalid = 0; bus_readdata = 32'h0;
      if (is_rd && v.lat != 0) begin
        check("R2 single read", {bus_read, rsp_valid}, 2'b00);
        for (int i = 1; i < int'(v.lat); i++) @(negedge clk);
        bus_readdatavalid = 1; bus_readdata = v.dat;
        @(posedge clk);
        @(negedge clk);
        bus_readdatavalid = 0; bus_readdata = 32'h0;
      end
      check(is_rd ? "R2 one transfer" : "R4 one transfer", xfer_cnt, cnt0 + 1);
      if (is_rd) take_rsp("R6", 4'd2, 4'd0, v.tid, v.dat);
      else       take_rsp("R7", 4'd3, 4'd0, v.tid, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {req_ready, rsp_valid, side_valid, bus_read, bus_write}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    check("R11 after reset", {req_ready, rsp_valid, side_valid, bus_read, bus_write}, 5'b10000);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R6: stray readdatavalid with nothing pending
    @(negedge clk);
    bus_readdatavalid = 1; bus_readdata = 32'h7777_7777;
    @(posedge clk);
    @(negedge clk);
    bus_readdatavalid = 0;
    @(negedge clk);
    check("R6 stray data ignored", {rsp_valid, req_ready}, 2'b01);

    // R11: reset during a stalled read drops it
    req_ttype = 0; req_size = 4'b1000; req_tid = 8'hCC; req_offset = 21'h10; req_wdptr = 0;
    req_valid = 1; bus_waitrequest = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R11 read in flight", bus_read, 1);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1; bus_waitrequest = 0;
    check("R11 dropped by reset", {req_ready, rsp_valid, side_valid, bus_read, bus_write}, 5'b10000);
    @(negedge clk);
    check("R11 no late response", rsp_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule